// File: doc/BRIEF.md
# Digital Input Conditioning Block

This block turns a small set of raw digital input pins into one 32-bit input status word. Each pin first passes through a synchronizer. Software may then replace its value with a forced one and may flip its polarity to get normally-closed behaviour. Every input shows up twice in the word. Its conditioned level sits in the upper half, at bit 16 for input 1, bit 17 for input 2 and so on, and this copy is never gated. The first three inputs also drive special-function flags in the lower half: negative limit, positive limit and home. Each flag passes only when its enable bit is set.

Software sets up the block through a simple register bus. An access FSM on that bus moves through four named states:
- **IDLE** waits for a request and captures its address and data.
- **IDLE→WRITE** or **IDLE→READ** is taken when the request is a write or a read.
- **WRITE** commits the captured data to a register.
- **READ** latches the selected value into the read-data register.
- **WRITE→DONE** and **READ→DONE** always follow.
- **DONE** raises `bus_ready` for one cycle.
- **DONE→IDLE** always follows.

The synchronized raw levels can be read back. The threshold-select bits are only stored and driven out to the analog front end.

Top module: `din_cond_top`

## Requirements
- R1: After reset every configuration register reads 0, `status_word` is 0 (with all pins low), `thresh_sel` is 0 and `bus_ready` is 0.
- R2: Status bit 16+i carries the conditioned value of input i+1 for every input. The enable register (address 1) has no effect on these bits.
- R3: Status bits 0, 1 and 2 carry the conditioned values of inputs 1, 2 and 3 ANDed with bits 0, 1 and 2 of the enable register (address 1).
- R4: Bit i of the invert register (address 2) set to 1 makes input i+1 read as the complement of its value (normally closed). Set to 0, the value passes unchanged.
- R5: Bit i of the force-enable register (address 3) set to 1 substitutes bit i of the force-value register (address 4) for the physical value of input i+1. Substitution happens before inversion.
- R6: The raw register (address 5) returns the synchronized pin levels in bits 0..5. It is unaffected by force and invert.
- R7: The threshold register (address 6) stores bits 0..3, one per input starting at input 1. It drives them on `thresh_sel[3:0]`. Bits 4 and 5 read 0 and are driven 0.
- R8: Status bits 3..15 and 22..31 are always 0. Register bits with no storage read 0: enable bits above 2, and bits above 5 elsewhere.
- R9: A pin change appears in `status_word` exactly three rising edges after it is applied: two synchronizer stages, then the status register.
- R10: An accepted request gives `bus_ready` high for exactly one cycle, two edges after acceptance (IDLE→WRITE/READ→DONE). Read data is valid while `bus_ready` is high.
- R11: A read of address 0 returns the current status word.
- R12: Address 7 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_pins | input | 6 | Raw asynchronous input levels, bit 0 = input 1 |
| bus_valid | input | 1 | Register access request, held until `bus_ready` |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion strobe |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| status_word | output | 32 | Conditioned input status word |
| thresh_sel | output | 6 | Stored threshold selections, bit 0 = input 1 |

## Verification
The bench builds the block with its default parameters: six inputs, three special functions, four threshold-capable inputs and a 32-bit word. With these values, the unused status bits 3..15 and 22..31 are real bits that the bench can check. The narrowing of the threshold register at bit 4 and the narrowing of the enable register at bit 3 also become visible through all-ones writes. The three-edge pin-to-status latency is fixed at the default synchronizer depth of two.

// File: rtl/din_cond_pkg.sv
package din_cond_pkg;

    typedef enum logic [1:0] {
        BS_IDLE  = 2'd0,
        BS_WRITE = 2'd1,
        BS_READ  = 2'd2,
        BS_DONE  = 2'd3
    } bus_state_t;

    localparam int REG_STATUS = 0;
    localparam int REG_FUNCEN = 1;
    localparam int REG_INVERT = 2;
    localparam int REG_FRCEN  = 3;
    localparam int REG_FRCVAL = 4;
    localparam int REG_RAW    = 5;
    localparam int REG_THRESH = 6;

endpackage

// File: rtl/din_sync.sv
module din_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain <= '0;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[b]};
                end
            end
            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/din_cfg_regs.sv
module din_cfg_regs
    import din_cond_pkg::*;
#(
    parameter int NUM_IN   = 6,
    parameter int NUM_FUNC = 3,
    parameter int NUM_THR  = 4,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] status_in,
    input  logic [NUM_IN-1:0] raw_in,
    output logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [NUM_FUNC-1:0] func_en,
    output logic [NUM_IN-1:0] invert,
    output logic [NUM_IN-1:0] force_en,
    output logic [NUM_IN-1:0] force_val,
    output logic [NUM_IN-1:0] thresh
);

    bus_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [NUM_IN-1:0] wdata_q;
    logic [NUM_FUNC-1:0] en_q;
    logic [NUM_IN-1:0] inv_q, fen_q, fval_q;
    logic [NUM_THR-1:0] thr_q;
    logic [DATA_W-1:0] rdata_q, rd_mux;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^req_wdata[DATA_W-1:NUM_IN];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BS_IDLE:  if (req_valid) state_d = req_write ? BS_WRITE : BS_READ;
            BS_WRITE: state_d = BS_DONE;
            BS_READ:  state_d = BS_DONE;
            BS_DONE:  state_d = BS_IDLE;
            default:  state_d = BS_IDLE;
        endcase
    end

    // outputs of the FSM
    always_comb begin
        rsp_ready = 1'b0;
        unique case (state_q)
            BS_IDLE:  rsp_ready = 1'b0;
            BS_WRITE: rsp_ready = 1'b0;
            BS_READ:  rsp_ready = 1'b0;
            BS_DONE:  rsp_ready = 1'b1;
            default:  rsp_ready = 1'b0;
        endcase
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == BS_IDLE && req_valid) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata[NUM_IN-1:0];
        end
    end

    // configuration storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            inv_q  <= '0;
            fen_q  <= '0;
            fval_q <= '0;
            thr_q  <= '0;
        end else if (state_q == BS_WRITE) begin
            if (addr_q == ADDR_W'(REG_FUNCEN)) en_q   <= wdata_q[NUM_FUNC-1:0];
            if (addr_q == ADDR_W'(REG_INVERT)) inv_q  <= wdata_q;
            if (addr_q == ADDR_W'(REG_FRCEN))  fen_q  <= wdata_q;
            if (addr_q == ADDR_W'(REG_FRCVAL)) fval_q <= wdata_q;
            if (addr_q == ADDR_W'(REG_THRESH)) thr_q  <= wdata_q[NUM_THR-1:0];
        end
    end

    // read selection
    always_comb begin
        rd_mux = '0;
        if      (addr_q == ADDR_W'(REG_STATUS)) rd_mux = status_in;
        else if (addr_q == ADDR_W'(REG_FUNCEN)) rd_mux = DATA_W'(en_q);
        else if (addr_q == ADDR_W'(REG_INVERT)) rd_mux = DATA_W'(inv_q);
        else if (addr_q == ADDR_W'(REG_FRCEN))  rd_mux = DATA_W'(fen_q);
        else if (addr_q == ADDR_W'(REG_FRCVAL)) rd_mux = DATA_W'(fval_q);
        else if (addr_q == ADDR_W'(REG_RAW))    rd_mux = DATA_W'(raw_in);
        else if (addr_q == ADDR_W'(REG_THRESH)) rd_mux = DATA_W'(thr_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (state_q == BS_READ) begin
            rdata_q <= rd_mux;
        end
    end

    assign rsp_rdata = rdata_q;
    assign func_en   = en_q;
    assign invert    = inv_q;
    assign force_en  = fen_q;
    assign force_val = fval_q;
    assign thresh    = NUM_IN'(thr_q);

endmodule

// File: rtl/din_condition.sv
module din_condition #(
    parameter int NUM_IN   = 6,
    parameter int NUM_FUNC = 3,
    parameter int DATA_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] level_in,
    input  logic [NUM_IN-1:0] force_en,
    input  logic [NUM_IN-1:0] force_val,
    input  logic [NUM_IN-1:0] invert,
    input  logic [NUM_FUNC-1:0] func_en,
    output logic [DATA_W-1:0] status
);

    localparam int LEVEL_BASE = DATA_W / 2;

    logic [NUM_IN-1:0] picked, cond;
    logic [DATA_W-1:0] status_d;

    generate
        for (genvar i = 0; i < NUM_IN; i++) begin : g_cond
            assign picked[i] = force_en[i] ? force_val[i] : level_in[i];
            assign cond[i]   = picked[i] ^ invert[i];
        end
    endgenerate

    always_comb begin
        status_d = '0;
        for (int i = 0; i < NUM_IN; i++) begin
            status_d[LEVEL_BASE + i] = cond[i];
        end
        for (int f = 0; f < NUM_FUNC; f++) begin
            status_d[f] = cond[f] & func_en[f];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= status_d;
        end
    end

endmodule

// File: rtl/din_cond_top.sv
module din_cond_top #(
    parameter int NUM_IN      = 6,
    parameter int NUM_FUNC    = 3,
    parameter int NUM_THR     = 4,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] in_pins,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] status_word,
    output logic [NUM_IN-1:0] thresh_sel
);

    logic [NUM_IN-1:0]   sync_q;
    logic [NUM_FUNC-1:0] func_en;
    logic [NUM_IN-1:0]   invert, force_en, force_val;

    din_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (in_pins),
        .sync_out (sync_q)
    );

    din_cfg_regs #(
        .NUM_IN(NUM_IN), .NUM_FUNC(NUM_FUNC), .NUM_THR(NUM_THR),
        .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_valid),
        .req_write (bus_write),
        .req_addr  (bus_addr),
        .req_wdata (bus_wdata),
        .status_in (status_word),
        .raw_in    (sync_q),
        .rsp_ready (bus_ready),
        .rsp_rdata (bus_rdata),
        .func_en   (func_en),
        .invert    (invert),
        .force_en  (force_en),
        .force_val (force_val),
        .thresh    (thresh_sel)
    );

    din_condition #(.NUM_IN(NUM_IN), .NUM_FUNC(NUM_FUNC), .DATA_W(DATA_W)) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_in  (sync_q),
        .force_en  (force_en),
        .force_val (force_val),
        .invert    (invert),
        .func_en   (func_en),
        .status    (status_word)
    );

endmodule

// File: rtl/din_cond_checker.sv
module din_cond_checker #(
    parameter int NUM_IN   = 6,
    parameter int NUM_FUNC = 3,
    parameter int NUM_THR  = 4,
    parameter int DATA_W   = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_IN-1:0] in_pins,
    input logic [NUM_IN-1:0] sync_q,
    input logic [DATA_W-1:0] status_word,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [NUM_IN-1:0] thresh_sel
);

    localparam int LEVEL_BASE = DATA_W / 2;

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R10: completion strobe lasts one cycle
    a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R10: completion comes two edges after the request was accepted
    a_r10_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> $past(bus_valid, 2));

    // R9: synchronizer output is the pin value two edges back
    a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (sync_q == $past(in_pins, 2)));

    // R3: a set flag implies the matching level bit is set
    a_r3_flag_has_level: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[0] |-> status_word[LEVEL_BASE]);

    // R7: threshold bits beyond the capable inputs stay low
    a_r7_thresh_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        thresh_sel[NUM_IN-1:NUM_THR] == '0);

    // R8: status bits between flags and levels stay low
    a_r8_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[LEVEL_BASE-1:NUM_FUNC] == '0);

endmodule

bind din_cond_top din_cond_checker #(
    .NUM_IN(NUM_IN), .NUM_FUNC(NUM_FUNC), .NUM_THR(NUM_THR), .DATA_W(DATA_W)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_pins     (in_pins),
    .sync_q      (sync_q),
    .status_word (status_word),
    .bus_valid   (bus_valid),
    .bus_ready   (bus_ready),
    .thresh_sel  (thresh_sel)
);

// File: tb/din_cond_top_test.sv
`timescale 1ns/1ps
module din_cond_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  in_pins = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [31:0] status_word;
    logic [5:0]  thresh_sel;

    int checks = 0;
    int failures = 0;
    int bus_cycles = 0;

    logic [2:0] m_en;
    logic [5:0] m_inv, m_fen, m_fval;

    always #4 clk = ~clk;

    din_cond_top uut (
        .clk(clk), .rst_n(rst_n), .in_pins(in_pins),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .status_word(status_word), .thresh_sel(thresh_sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [5:0] p);
        logic [5:0] c;
        logic [31:0] s;
        c = ((m_fen & m_fval) | (~m_fen & p)) ^ m_inv;
        s = '0;
        s[21:16] = c;
        s[2:0] = c[2:0] & m_en;
        return s;
    endfunction

    task automatic bus_op(input logic wr, input logic [2:0] a, input logic [31:0] d,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        bus_cycles = 0;
        do begin
            @(negedge clk);
            bus_cycles++;
        end while (!bus_ready && bus_cycles < 20);
        rd = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        bus_op(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_op(1'b0, a, 32'h0, d);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [2:0] en, input logic [5:0] inv,
                           input logic [5:0] fen, input logic [5:0] fval);
        m_en = en; m_inv = inv; m_fen = fen; m_fval = fval;
        wr(3'd1, 32'(en)); wr(3'd2, 32'(inv)); wr(3'd3, 32'(fen)); wr(3'd4, 32'(fval));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 status", status_word, 32'h0);
        check("R1 thresh", 32'(thresh_sel), 32'h0);
        check("R1 ready", 32'(bus_ready), 32'h0);
        for (int a = 1; a <= 6; a++) begin
            if (a != 5) begin
                rd(3'(a), d);
                check("R1 reg", d, 32'h0);
            end
        end
    endtask

    task automatic t_levels();
        logic [5:0] pats [3] = '{6'b101010, 6'b010101, 6'b111111};
        set_cfg(3'b000, 6'h0, 6'h0, 6'h0);
        foreach (pats[k]) begin
            in_pins = pats[k]; settle();
            check("R2 levels ungated", status_word, {10'h0, pats[k], 16'h0});
        end
    endtask

    task automatic t_flags();
        set_cfg(3'b111, 6'h0, 6'h0, 6'h0);
        in_pins = 6'b000101; settle();
        check("R3 flags all enabled", status_word, model(in_pins));
        check("R3 flag value", 32'(status_word[2:0]), 32'h5);
        set_cfg(3'b010, 6'h0, 6'h0, 6'h0);
        in_pins = 6'b000111; settle();
        check("R3 only positive limit", status_word, 32'h0007_0002);
    endtask

    task automatic t_invert();
        set_cfg(3'b111, 6'b000011, 6'h0, 6'h0);
        in_pins = 6'b000000; settle();
        check("R4 invert low pins", status_word, 32'h0003_0003);
        in_pins = 6'b110011; settle();
        check("R4 invert mixed", status_word, model(in_pins));
    endtask

    task automatic t_force();
        set_cfg(3'b111, 6'b000001, 6'b100001, 6'b100000);
        in_pins = 6'b000001; settle();
        // input1 forced 0 then inverted -> 1; input6 forced 1
        check("R5 force then invert", status_word, 32'h0021_0001);
        check("R5 model", status_word, model(in_pins));
        in_pins = 6'b011110; settle();
        check("R5 force ignores pin", status_word, model(in_pins));
    endtask

    task automatic t_raw();
        logic [31:0] d;
        in_pins = 6'b101101; settle();
        rd(3'd5, d);
        check("R6 raw under force/invert", d, 32'h2D);
    endtask

    task automatic t_thresh();
        logic [31:0] d;
        wr(3'd6, 32'hFFFF_FFFF);
        rd(3'd6, d);
        check("R7 thresh readback", d, 32'h0F);
        check("R7 thresh port", 32'(thresh_sel), 32'h0F);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        set_cfg(3'b111, 6'h0, 6'h0, 6'h0);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, d);
        check("R8 enable width", d, 32'h7);
        wr(3'd2, 32'hFFFF_FFC0);
        rd(3'd2, d);
        check("R8 invert width", d, 32'h0);
        in_pins = 6'h3F; settle();
        check("R8 unused status bits", status_word & 32'hFFC0_FFF8, 32'h0);
    endtask

    task automatic t_latency();
        set_cfg(3'b000, 6'h0, 6'h0, 6'h0);
        in_pins = 6'h00; settle();
        @(negedge clk);
        in_pins = 6'b000100;
        repeat (2) @(negedge clk);
        check("R9 not yet after two edges", status_word, 32'h0);
        @(negedge clk);
        check("R9 visible after three edges", status_word, 32'h0004_0000);
    endtask

    task automatic t_bus();
        logic [31:0] d;
        rd(3'd0, d);
        check("R10 two cycles to ready", 32'(bus_cycles), 32'd2);
        @(negedge clk);
        check("R10 ready drops", 32'(bus_ready), 32'h0);
        wr(3'd4, 32'h15);
        check("R10 write two cycles", 32'(bus_cycles), 32'd2);
    endtask

    task automatic t_status_read();
        logic [31:0] d;
        set_cfg(3'b101, 6'h0, 6'h0, 6'h0);
        in_pins = 6'b100101; settle();
        rd(3'd0, d);
        check("R11 status via bus", d, model(in_pins));
        check("R11 matches port", d, status_word);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        set_cfg(3'b011, 6'h05, 6'h0A, 6'h22);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7, d);
        check("R12 unmapped reads 0", d, 32'h0);
        rd(3'd1, d); check("R12 enable intact", d, 32'h3);
        rd(3'd2, d); check("R12 invert intact", d, 32'h05);
        rd(3'd3, d); check("R12 force enable intact", d, 32'h0A);
        rd(3'd4, d); check("R12 force value intact", d, 32'h22);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        m_en = '0; m_inv = '0; m_fen = '0; m_fval = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_levels();
        t_flags();
        t_invert();
        t_force();
        t_raw();
        t_thresh();
        t_unused();
        t_latency();
        t_bus();
        t_status_read();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule